// File: doc/BRIEF.md
# Two-Channel Polynomial Tone Generator

This block is the tone source of a two-channel retro sound unit. Each channel holds three small registers: a 4-bit waveform mode, a 5-bit pitch value and a 4-bit loudness. Every cycle in which `tick_en` is high counts as one chip tick. Each channel divides these ticks by its pitch value plus one. On every divider pulse, the channel advances a 4-bit shift register and a 5-bit shift register. The 5-bit register also carries a sixth carry bit. The mode selects how the two registers step. The single-bit tone of a channel is bit 3 of its 4-bit register. The loudness register is passed straight to the output beside the tone. Mixing and sample-rate conversion happen elsewhere.

A single write port and a combinational read port reach all six registers. The 5-bit register's own stepping rule is a linear feedback shift that takes bit 4 XOR bit 2. The 4-bit register's own stepping rule takes bit 3 XOR bit 2. The modes combine these two shifters with a constant-one fill, a divide-by-2 toggle, a divide-by-6 sequencer, a divide-by-31 gate and a joined 9-bit shifter.

Top module: `snd_tone_unit`

## Requirements
- R1: The register addresses are: mode 0x15/0x16, pitch 0x17/0x18 and loudness 0x19/0x1A, for channel 0 and channel 1 respectively. A write keeps only the low 4, 5 and 4 bits of the data. `rdata` returns the addressed register, zero-extended, in the same cycle.
- R2: A read of any other address returns 0. A write to any other address changes no register and no output.
- R3: While `rst_n` is low at a clock edge, all registers are cleared and the divider count goes to 0. The 4-bit and 5-bit shifters are set to 1, so both tones read 0.
- R4: A channel's divider pulses once every (pitch + 1) cycles that have `tick_en` high. Cycles with `tick_en` low leave the divider and the shifters unchanged.
- R5: A write to a channel's pitch register restarts its count from zero. The channel does not step in the cycle of that write.
- R6: Modes 0 and 11 shift a 1 into the 4-bit register. Modes 4 and 5 shift in the inverse of bit 0. Mode 1 steps the 4-bit shifter. If the 4-bit register is all zero, it reloads to 1.
- R7: Modes 12 and 13 set the 4-bit register to its complement shifted left by one. The new bit 0 is 1 only when bit 2 is 0 and bits 2..0 are not all 0. The tone then follows the repeating pattern 000111.
- R8: Mode 9 steps the 5-bit shifter and shifts its carry bit 5 into the 4-bit register. Mode 8 steps a joined 9-bit shifter. Its 5-bit part shifts in 4-bit bit 3 XOR 5-bit bit 4, and it reloads to 1 only if both parts are zero. Its 4-bit part then shifts in the new carry bit 5.
- R9: Modes 2, 6, 10 and 14 step the 5-bit shifter. The 4-bit register then advances only when the new low four bits of the 5-bit register equal 1000b. The 4-bit step is the mode 1, divide-by-2, bit-4 fill or divide-by-6 rule, respectively.
- R10: Modes 3, 7 and 15 step the 5-bit shifter. The 4-bit register then advances only when the new bit 4 is 1. The 4-bit step is the mode 1, divide-by-2 or divide-by-6 rule, respectively.
- R11: `tone_o[c]` equals bit 3 of channel c's 4-bit register and changes on the clock edge of the pulse. `vol_o[4c+3:4c]` equals channel c's loudness register.
- R12: The two channels step independently: the mode and pitch of one do not affect the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One chip tick per cycle when high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| tone_o | output | 2 | Tone bit per channel |
| vol_o | output | 8 | Loudness per channel, channel 0 in bits 3:0 |

## Verification
A mistake in a shifter feedback tap or in a divide-by-31 gate condition shows up only at the tone pin. Only one bit of the four is visible there, so a single wrong step can stay hidden for a few pulses. The sequence then diverges within about a dozen steps. For this reason every mode is compared against an independent step model over sixty pulses per channel. A divider count that is off by one moves the first tone edge by whole periods, and the edge is checked to the exact cycle.

// File: rtl/snd_pkg.sv
// Package snd_pkg
// Shared widths and the per-pulse step rule of the two shift registers.
// Assumes: 4-bit mode code, 4-bit shifter, 5-bit shifter plus one carry bit.
package snd_pkg;

    localparam int MODE_W = 4;
    localparam int FREQ_W = 5;
    localparam int VOL_W  = 4;
    localparam int SR4_W  = 4;
    localparam int SR5_W  = 5;

    typedef struct packed {
        logic [SR4_W-1:0] sr4;
        logic [SR5_W:0]   sr5;   // bit SR5_W is the carry out of the last shift
    } poly_t;

    // Computes the shifter state after one divider pulse in the given mode.
    function automatic poly_t poly_step(input logic [MODE_W-1:0] mode, input poly_t cur);
        poly_t            nxt;
        logic [SR4_W-1:0] lfsr4;
        logic [SR4_W-1:0] fill1;
        logic [SR4_W-1:0] half;
        logic [SR4_W-1:0] six;
        logic [SR5_W:0]   lfsr5;
        logic [SR5_W:0]   join9;
        logic             gate31;
        logic             gate5;
        lfsr4  = (cur.sr4 != '0) ? {cur.sr4[2:0], cur.sr4[3] ^ cur.sr4[2]} : 4'd1;
        fill1  = {cur.sr4[2:0], 1'b1};
        half   = {cur.sr4[2:0], ~cur.sr4[0]};
        six    = {~cur.sr4[2:0], ~cur.sr4[2] & (cur.sr4[2:0] != 3'd0)};
        lfsr5  = (cur.sr5[4:0] != '0) ? {cur.sr5[4:0], cur.sr5[4] ^ cur.sr5[2]} : 6'd1;
        join9  = ((cur.sr5[4:0] != '0) || (cur.sr4 != '0))
                 ? {cur.sr5[4:0], cur.sr4[3] ^ cur.sr5[4]} : 6'd1;
        gate31 = (lfsr5[3:0] == 4'b1000);
        gate5  = lfsr5[4];
        nxt    = cur;
        case (mode)
            4'd0, 4'd11: nxt.sr4 = fill1;
            4'd1:        nxt.sr4 = lfsr4;
            4'd4, 4'd5:  nxt.sr4 = half;
            4'd12, 4'd13: nxt.sr4 = six;
            4'd8: begin
                nxt.sr5 = join9;
                nxt.sr4 = {cur.sr4[2:0], join9[SR5_W]};
            end
            4'd9: begin
                nxt.sr5 = lfsr5;
                nxt.sr4 = {cur.sr4[2:0], lfsr5[SR5_W]};
            end
            4'd2: begin
                nxt.sr5 = lfsr5;
                if (gate31) nxt.sr4 = lfsr4;
            end
            4'd6: begin
                nxt.sr5 = lfsr5;
                if (gate31) nxt.sr4 = half;
            end
            4'd10: begin
                nxt.sr5 = lfsr5;
                if (gate31) nxt.sr4 = {cur.sr4[2:0], lfsr5[4]};
            end
            4'd14: begin
                nxt.sr5 = lfsr5;
                if (gate31) nxt.sr4 = six;
            end
            4'd3: begin
                nxt.sr5 = lfsr5;
                if (gate5) nxt.sr4 = lfsr4;
            end
            4'd7: begin
                nxt.sr5 = lfsr5;
                if (gate5) nxt.sr4 = half;
            end
            default: begin
                nxt.sr5 = lfsr5;
                if (gate5) nxt.sr4 = six;
            end
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/snd_freq_div.sv
// Module snd_freq_div
// Counts enabled ticks and pulses once every (div_val + 1) of them.
// Assumes: reload wins over a tick in the same cycle; div_val is a registered value.
module snd_freq_div #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             reload,
    input  logic [CNT_W-1:0] div_val,
    output logic             pulse
);

    logic [CNT_W-1:0] cnt_q;

    // A pulse fires on the tick that finds the count at the limit.
    always_comb begin
        pulse = tick_en && !reload && (cnt_q == div_val);
    end

    // Counter: restarts on reset, reload or pulse, else advances per tick.
    always_ff @(posedge clk) begin
        if (!rst_n || reload || pulse) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/snd_poly_gen.sv
// Module snd_poly_gen
// Holds the two shift registers of one channel and steps them on each pulse.
// Assumes: mode may change at any time; state is never cleared by a mode change.
module snd_poly_gen
    import snd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [MODE_W-1:0] mode,
    output logic              tone
);

    poly_t state_q;

    // Shift registers: set to one on reset, advanced on every pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.sr4 <= SR4_W'(1);
            state_q.sr5 <= (SR5_W + 1)'(1);
        end else if (step) begin
            state_q <= poly_step(mode, state_q);
        end
    end

    // The tone is the top bit of the 4-bit register.
    always_comb begin
        tone = state_q.sr4[SR4_W-1];
    end

endmodule

// File: rtl/snd_channel.sv
// Module snd_channel
// One tone channel: mode, pitch and loudness registers, divider and shifters.
// Assumes: the write strobes are decoded one-hot by the parent.
module snd_channel
    import snd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_mode,
    input  logic              wr_freq,
    input  logic              wr_vol,
    input  logic [DATA_W-1:0] wdata,
    output logic [MODE_W-1:0] mode_q,
    output logic [FREQ_W-1:0] freq_q,
    output logic [VOL_W-1:0]  vol_q,
    output logic              tone
);

    logic pulse;

    // Register file: clears on reset, keeps only the low bits of each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            freq_q <= '0;
            vol_q  <= '0;
        end else begin
            if (wr_mode) mode_q <= wdata[MODE_W-1:0];
            if (wr_freq) freq_q <= wdata[FREQ_W-1:0];
            if (wr_vol)  vol_q  <= wdata[VOL_W-1:0];
        end
    end

    snd_freq_div #(
        .CNT_W (FREQ_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .reload  (wr_freq),
        .div_val (freq_q),
        .pulse   (pulse)
    );

    snd_poly_gen u_poly (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (pulse),
        .mode  (mode_q),
        .tone  (tone)
    );

endmodule

// File: rtl/snd_tone_unit.sv
// Module snd_tone_unit
// Two tone channels behind one address decoder with combinational readback.
// Assumes: channel c's registers sit at each base address plus c.
module snd_tone_unit
    import snd_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter int              DATA_W    = 8,
    parameter int              NUM_CH    = 2,
    parameter logic [ADDR_W-1:0] MODE_BASE = 8'h15,
    parameter logic [ADDR_W-1:0] FREQ_BASE = 8'h17,
    parameter logic [ADDR_W-1:0] VOL_BASE  = 8'h19
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_en,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rdata,
    output logic [NUM_CH-1:0]       tone_o,
    output logic [NUM_CH*VOL_W-1:0] vol_o
);

    logic [NUM_CH-1:0] hit_mode;
    logic [NUM_CH-1:0] hit_freq;
    logic [NUM_CH-1:0] hit_vol;
    logic [MODE_W-1:0] mode_r [NUM_CH];
    logic [FREQ_W-1:0] freq_r [NUM_CH];
    logic [VOL_W-1:0]  vol_r  [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Address match for this channel's three registers.
        always_comb begin
            hit_mode[c] = (addr == MODE_BASE + ADDR_W'(c));
            hit_freq[c] = (addr == FREQ_BASE + ADDR_W'(c));
            hit_vol[c]  = (addr == VOL_BASE  + ADDR_W'(c));
        end

        snd_channel #(
            .DATA_W (DATA_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (tick_en),
            .wr_mode (wr_en && hit_mode[c]),
            .wr_freq (wr_en && hit_freq[c]),
            .wr_vol  (wr_en && hit_vol[c]),
            .wdata   (wdata),
            .mode_q  (mode_r[c]),
            .freq_q  (freq_r[c]),
            .vol_q   (vol_r[c]),
            .tone    (tone_o[c])
        );

        // Loudness is passed to the output lane of this channel.
        always_comb begin
            vol_o[c*VOL_W +: VOL_W] = vol_r[c];
        end
    end

    // Readback: the matching register zero-extended, zero for no match.
    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit_mode[c]) rdata = DATA_W'(mode_r[c]);
            if (hit_freq[c]) rdata = DATA_W'(freq_r[c]);
            if (hit_vol[c])  rdata = DATA_W'(vol_r[c]);
        end
    end

endmodule

// File: rtl/snd_tone_unit_chk.sv
// Module snd_tone_unit_chk
// Port-level temporal checks for snd_tone_unit, attached by bind.
// Assumes: channel 0 registers at the base addresses.
module snd_tone_unit_chk #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter int                NUM_CH    = 2,
    parameter int                VOL_W     = 4,
    parameter logic [ADDR_W-1:0] FREQ_BASE = 8'h17,
    parameter logic [ADDR_W-1:0] VOL_BASE  = 8'h19
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick_en,
    input logic                    wr_en,
    input logic [ADDR_W-1:0]       addr,
    input logic [DATA_W-1:0]       wdata,
    input logic [NUM_CH-1:0]       tone_o,
    input logic [NUM_CH*VOL_W-1:0] vol_o
);

    // R3
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (tone_o == '0 && vol_o == '0));

    // R4
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(tone_o));

    // R5
    freq_write_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == FREQ_BASE) |=> $stable(tone_o[0]));

    // R11
    vol_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == VOL_BASE) |=> (vol_o[VOL_W-1:0] == $past(wdata[VOL_W-1:0])));

endmodule

bind snd_tone_unit snd_tone_unit_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_CH    (NUM_CH),
    .VOL_W     (snd_pkg::VOL_W),
    .FREQ_BASE (FREQ_BASE),
    .VOL_BASE  (VOL_BASE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .tone_o  (tone_o),
    .vol_o   (vol_o)
);

// File: tb/snd_tone_unit_bench.sv
module snd_tone_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [1:0] tone_o;
    logic [7:0] vol_o;

    int n_checks = 0;
    int n_errors = 0;
    int mp4 [2];
    int mp5 [2];

    always #2 clk = ~clk;

    snd_tone_unit u_snd_tone_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .tone_o  (tone_o),
        .vol_o   (vol_o)
    );

    typedef struct packed {
        logic [3:0] mode;
        logic [4:0] freq;
        logic [7:0] exp_bits;   // bit i = tone after pulse i+1
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{4'd0,  5'd0, 8'hFC},
        '{4'd1,  5'd0, 8'h64},
        '{4'd4,  5'd0, 8'h54},
        '{4'd12, 5'd0, 8'h71},
        '{4'd9,  5'd0, 8'h84},
        '{4'd4,  5'd2, 8'h54},
        '{4'd1,  5'd1, 8'h64}
    };

    task automatic check(input string req, input int got, input int exp, input string what);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mp4[0] = 1; mp4[1] = 1; mp5[0] = 1; mp5[1] = 1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    // Applies n enabled ticks; returns at a falling edge.
    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    // Independent step model written from the requirement text.
    function automatic int l4(input int x);
        if ((x & 15) == 0) return 1;
        return ((x << 1) | (((x >> 3) ^ (x >> 2)) & 1)) & 15;
    endfunction

    function automatic int l5(input int y);
        if ((y & 31) == 0) return 1;
        return ((y << 1) | (((y >> 4) ^ (y >> 2)) & 1)) & 63;
    endfunction

    function automatic int d6(input int x);
        int b;
        b = (((x & 4) == 0) && ((x & 7) != 0)) ? 1 : 0;
        return ((~x << 1) | b) & 15;
    endfunction

    task automatic model_step(input int c, input int m);
        int x; int y; int g31; int g5;
        x = mp4[c]; y = mp5[c];
        if (m == 8) begin
            y = ((y & 31) != 0 || (x & 15) != 0) ? (((y << 1) | (((x >> 3) ^ (y >> 4)) & 1)) & 63) : 1;
            x = ((x << 1) | ((y >> 5) & 1)) & 15;
        end else if (m == 0 || m == 11) x = ((x << 1) | 1) & 15;
        else if (m == 1) x = l4(x);
        else if (m == 4 || m == 5) x = ((x << 1) | ((x & 1) ^ 1)) & 15;
        else if (m == 12 || m == 13) x = d6(x);
        else begin
            y = l5(y);
            g31 = ((y & 15) == 8);
            g5 = ((y >> 4) & 1);
            case (m)
                9:  x = ((x << 1) | ((y >> 5) & 1)) & 15;
                2:  if (g31 != 0) x = l4(x);
                6:  if (g31 != 0) x = ((x << 1) | ((x & 1) ^ 1)) & 15;
                10: if (g31 != 0) x = ((x << 1) | ((y >> 4) & 1)) & 15;
                14: if (g31 != 0) x = d6(x);
                3:  if (g5 != 0) x = l4(x);
                7:  if (g5 != 0) x = ((x << 1) | ((x & 1) ^ 1)) & 15;
                default: if (g5 != 0) x = d6(x);
            endcase
        end
        mp4[c] = x; mp5[c] = y;
    endtask

    function automatic string mode_req(input int m);
        case (m)
            0, 1, 4, 5, 11: return "R6";
            12, 13:         return "R7";
            8, 9:           return "R8";
            2, 6, 10, 14:   return "R9";
            default:        return "R10";
        endcase
    endfunction

    bit done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int v;
        logic [7:0] got;

        // R3: reset state
        do_reset();
        check("R3", int'(tone_o), 0, "tone after reset");
        check("R3", int'(vol_o), 0, "volume after reset");
        for (int a = 8'h15; a <= 8'h1A; a++) begin
            rd(8'(a), v);
            check("R3", v, 0, $sformatf("register %0h after reset", a));
        end

        // R1: masking and readback for every register
        wr(8'h15, 8'hFF); wr(8'h16, 8'hA7); wr(8'h17, 8'hFF);
        wr(8'h18, 8'h2C); wr(8'h19, 8'hFF); wr(8'h1A, 8'h36);
        rd(8'h15, v); check("R1", v, 8'h0F, "mode 0 mask");
        rd(8'h16, v); check("R1", v, 8'h07, "mode 1 mask");
        rd(8'h17, v); check("R1", v, 8'h1F, "pitch 0 mask");
        rd(8'h18, v); check("R1", v, 8'h0C, "pitch 1 mask");
        rd(8'h19, v); check("R1", v, 8'h0F, "loudness 0 mask");
        rd(8'h1A, v); check("R1", v, 8'h06, "loudness 1 mask");
        // R11: loudness passes through per lane
        check("R11", int'(vol_o), 8'h6F, "volume lanes");

        // R2: unmapped addresses
        wr(8'h14, 8'hFF); wr(8'h1B, 8'hFF); wr(8'h95, 8'h00);
        rd(8'h14, v); check("R2", v, 0, "read 0x14");
        rd(8'h1B, v); check("R2", v, 0, "read 0x1B");
        rd(8'h95, v); check("R2", v, 0, "read 0x95");
        rd(8'h15, v); check("R2", v, 8'h0F, "mode 0 after stray writes");
        rd(8'h18, v); check("R2", v, 8'h0C, "pitch 1 after stray writes");
        check("R2", int'(vol_o), 8'h6F, "volume after stray writes");
        check("R2", int'(tone_o), 0, "tone after stray writes");

        // Vector table on channel 0 (R6 R7 R8 R11 R4)
        foreach (VECS[i]) begin
            do_reset();
            wr(8'h15, 8'(VECS[i].mode));
            wr(8'h17, 8'(VECS[i].freq));
            got = '0;
            for (int s = 0; s < 8; s++) begin
                ticks(int'(VECS[i].freq) + 1);
                got[s] = tone_o[0];
            end
            check(VECS[i].freq == 0 ? mode_req(int'(VECS[i].mode)) : "R4",
                  int'(got), int'(VECS[i].exp_bits),
                  $sformatf("tone bits mode %0d pitch %0d", VECS[i].mode, VECS[i].freq));
        end

        // R4: exact period with pitch 4, mode 0 needs three pulses
        do_reset();
        wr(8'h17, 8'd4);
        ticks(14);
        check("R4", int'(tone_o[0]), 0, "tone before third pulse");
        @(negedge clk); @(negedge clk);
        check("R4", int'(tone_o[0]), 0, "tone held with no tick");
        ticks(1);
        check("R4", int'(tone_o[0]), 1, "tone at third pulse");

        // R5: pitch write restarts the count
        do_reset();
        wr(8'h17, 8'd4);
        ticks(13);
        wr(8'h17, 8'd4);
        ticks(4);
        check("R5", int'(tone_o[0]), 0, "no pulse before restarted count ends");
        ticks(1);
        check("R5", int'(tone_o[0]), 1, "pulse after restarted count");

        // Every mode on channel 1 against the model; channel 0 in mode 4 (R12)
        for (int m = 0; m < 16; m++) begin
            int bad1; int bad0;
            bad1 = 0; bad0 = 0;
            do_reset();
            wr(8'h16, 8'(m));
            wr(8'h15, 8'h04);
            wr(8'h17, 8'h01);
            for (int s = 0; s < 60; s++) begin
                ticks(1);
                model_step(1, m);
                if (s % 2 == 1) model_step(0, 4);
                if (int'(tone_o[1]) != ((mp4[1] >> 3) & 1)) bad1++;
                if (int'(tone_o[0]) != ((mp4[0] >> 3) & 1)) bad0++;
            end
            check(mode_req(m), bad1, 0, $sformatf("model mismatches mode %0d", m));
            check("R12", bad0, 0, $sformatf("channel 0 mismatches beside mode %0d", m));
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule